// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits between a local bus master and a serial link controller. It rewrites the addresses of locally initiated reads and writes that land in a fixed 256 MB outbound window, 0x6000_0000 to 0x6FFF_FFFF. The window is divided into 32 regions of equal size. Each region has a replacement value for its upper address bits and a 32-bit upper word, so that the result can reach a 64-bit link address.

A 2-bit size code sets the region size to 1, 2, 4 or 8 MB. The size code moves two fields together: the five address bits that choose the region, and the upper field that the region's programmed value replaces. A global switch turns translation on. While it is off, and for any address outside the window, the address passes through zero-extended to 64 bits. If an in-window address maps to a region that is not enabled, the block reports an error pulse and produces no result. Each accepted input gives its result one clock later.

Configuration arrives on a single-cycle write port. A 2-bit selector chooses the size code, the global switch, a region's offset word or a region's upper word. A 5-bit index names the region.

Top module: `obx_top`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, outValid, outHit and outErr are low.
- R2: An input presented with inValid high produces its result (outValid, or outErr for a disabled region) on the clock edge after the one that samples it. A new input may be presented on every cycle.
- R3: When the global switch (cfgSel=1, cfgData[0]) is clear, every input gives outValid=1, outHit=0 and outAddr = {32'h0, inAddr}.
- R4: When translation is on, an input whose bits [31:28] are not 4'h6 gives outValid=1, outHit=0 and outAddr = {32'h0, inAddr}.
- R5: For size code s (cfgSel=0, cfgData[1:0]), the region number is inAddr[24+s:20+s].
- R6: A translated result keeps inAddr[19+s:0] and takes bits [31:20+s] from the selected region's offset word (cfgSel=2), with outHit=1.
- R7: Bits [63:32] of a translated result equal the selected region's upper word (cfgSel=3).
- R8: Bit 0 of a region's offset word enables the region. An in-window input to a disabled region, with translation on, gives outErr=1 and outValid=0 for that one cycle.
- R9: A cycle with inValid low produces neither outValid nor outErr in the next cycle.
- R10: A configuration write (cfgWe=1; selector 0 size, 1 switch, 2 offset, 3 upper word; cfgIdx names the region) applies to inputs presented in the cycle after the write.
- R11: With size code 0, region 0 offset 0x9000_0001, upper word 0 and translation on, input 0x6001_5678 gives 0x0000_0000_9001_5678.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select: 0 size, 1 switch, 2 offset, 3 upper word |
| cfgIdx | input | 5 | Region index for offset and upper-word writes |
| cfgData | input | 32 | Write data |
| inValid | input | 1 | Input address valid |
| inAddr | input | 32 | Local address |
| outValid | output | 1 | Result valid |
| outAddr | output | 64 | Translated or passed-through address |
| outHit | output | 1 | The result was translated by a region |
| outErr | output | 1 | The address hit a disabled region |

## Verification
The in-RTL properties check on every cycle that results follow their input by exactly one cycle and that idle cycles stay silent. They also check that pass-through results equal the zero-extended input, that translated results keep the low 20 bits and carry the selected upper word, and that an error never comes with a valid result. The size-dependent region choice and the replaced field width for each size code are shown only by the bench's scenarios. The same holds for the timing of configuration writes against traffic and the worked 1 MB example. The bench compares each result with its own model of the register state.

// File: rtl/obx_pkg.sv
package obx_pkg;

  // Configuration register selector values
  localparam logic [1:0] SEL_SIZE = 2'd0;
  localparam logic [1:0] SEL_EN   = 2'd1;
  localparam logic [1:0] SEL_OFF  = 2'd2;
  localparam logic [1:0] SEL_HIGH = 2'd3;

  // Strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic takeXlate;
    logic takePass;
    logic raiseErr;
  } obxStrb_t;

endpackage

// File: rtl/obx_ctrl.sv
module obx_ctrl
  import obx_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REGION_CNT = 32,
  parameter int SIZE_W     = 2,
  parameter int MIN_SHIFT  = 20,
  parameter int WIN_BITS   = 28,
  parameter logic [31:0] WIN_BASE = 32'h6000_0000,
  localparam int IDX_W     = $clog2(REGION_CNT),
  localparam int SHIFT_W   = $clog2(ADDR_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] inAddr,
  output obxStrb_t          strb,
  output logic [ADDR_W-1:0] selOffset,
  output logic [ADDR_W-1:0] selHigh,
  output logic [SIZE_W-1:0] sizeCode
);

  localparam int TAG_W = ADDR_W - WIN_BITS;

  logic                              globalEn;
  logic [REGION_CNT-1:0][ADDR_W-1:0] offReg;
  logic [REGION_CNT-1:0][ADDR_W-1:0] highReg;
  logic [SHIFT_W-1:0]                shiftAmt;
  logic [IDX_W-1:0]                  regionIdx;
  logic                              winHit;
  logic                              regionOn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeCode <= '0;
      globalEn <= 1'b0;
    end else if (cfgWe) begin
      if (cfgSel == SEL_SIZE) sizeCode <= cfgData[SIZE_W-1:0];
      if (cfgSel == SEL_EN)   globalEn <= cfgData[0];
    end
  end

  for (genvar r = 0; r < REGION_CNT; r++) begin : g_region
    always_ff @(posedge clk) begin
      if (!rstN) begin
        offReg[r]  <= '0;
        highReg[r] <= '0;
      end else if (cfgWe && cfgIdx == IDX_W'(r)) begin
        if (cfgSel == SEL_OFF)  offReg[r]  <= cfgData;
        if (cfgSel == SEL_HIGH) highReg[r] <= cfgData;
      end
    end
  end

  always_comb begin
    shiftAmt  = SHIFT_W'(MIN_SHIFT) + SHIFT_W'(sizeCode);
    regionIdx = IDX_W'(inAddr >> shiftAmt);
    winHit    = inAddr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS];
    selOffset = offReg[regionIdx];
    selHigh   = highReg[regionIdx];
    regionOn  = selOffset[0];
  end

  always_comb begin
    strb = '0;
    if (inValid) begin
      if (!globalEn || !winHit) strb.takePass  = 1'b1;
      else if (regionOn)        strb.takeXlate = 1'b1;
      else                      strb.raiseErr  = 1'b1;
    end
  end

  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.takeXlate, strb.takePass, strb.raiseErr}));  // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> (strb == '0));  // R9
  AST_SIZE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgSel == SEL_SIZE) |=> (sizeCode == $past(cfgData[SIZE_W-1:0])));  // R10
  AST_XLATE_IN_WIN: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeXlate |-> (inAddr[ADDR_W-1:WIN_BITS] == TAG_W'(WIN_BASE >> WIN_BITS)));  // R4

endmodule

// File: rtl/obx_dp.sv
module obx_dp
  import obx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 2,
  parameter int MIN_SHIFT = 20,
  localparam int SHIFT_W  = $clog2(ADDR_W) + 1,
  localparam int OUT_W    = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  obxStrb_t          strb,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [ADDR_W-1:0] selOffset,
  input  logic [ADDR_W-1:0] selHigh,
  input  logic [SIZE_W-1:0] sizeCode,
  output logic              outValid,
  output logic [OUT_W-1:0]  outAddr,
  output logic              outHit,
  output logic              outErr
);

  logic [SHIFT_W-1:0] shiftAmt;
  logic [ADDR_W-1:0]  keepMask;
  logic [OUT_W-1:0]   xlateAddr;
  logic [OUT_W-1:0]   passAddr;

  always_comb begin
    shiftAmt  = SHIFT_W'(MIN_SHIFT) + SHIFT_W'(sizeCode);
    keepMask  = ~({ADDR_W{1'b1}} << shiftAmt);
    xlateAddr = {selHigh, (selOffset & ~keepMask) | (inAddr & keepMask)};
    passAddr  = {{ADDR_W{1'b0}}, inAddr};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outHit   <= 1'b0;
      outErr   <= 1'b0;
      outAddr  <= '0;
    end else begin
      outValid <= strb.takeXlate | strb.takePass;
      outHit   <= strb.takeXlate;
      outErr   <= strb.raiseErr;
      if (strb.takeXlate)     outAddr <= xlateAddr;
      else if (strb.takePass) outAddr <= passAddr;
    end
  end

  AST_LAT_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeXlate || strb.takePass) |=> outValid);  // R2
  AST_PASS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    strb.takePass |=> (!outHit && outAddr == {{ADDR_W{1'b0}}, $past(inAddr)}));  // R4
  AST_LOW_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeXlate |=> (outHit && outAddr[MIN_SHIFT-1:0] == $past(inAddr[MIN_SHIFT-1:0])));  // R6
  AST_HIGH_WORD: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeXlate |=> (outAddr[OUT_W-1:ADDR_W] == $past(selHigh)));  // R7
  AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strb.raiseErr |=> (outErr && !outValid));  // R8

endmodule

// File: rtl/obx_top.sv
module obx_top
  import obx_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REGION_CNT = 32,
  parameter int SIZE_W     = 2,
  parameter int MIN_SHIFT  = 20,
  parameter int WIN_BITS   = 28,
  parameter logic [31:0] WIN_BASE = 32'h6000_0000,
  localparam int IDX_W     = $clog2(REGION_CNT),
  localparam int OUT_W     = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] inAddr,
  output logic              outValid,
  output logic [OUT_W-1:0]  outAddr,
  output logic              outHit,
  output logic              outErr
);

  obxStrb_t          strb;
  logic [ADDR_W-1:0] selOffset;
  logic [ADDR_W-1:0] selHigh;
  logic [SIZE_W-1:0] sizeCode;

  obx_ctrl #(
    .ADDR_W(ADDR_W), .REGION_CNT(REGION_CNT), .SIZE_W(SIZE_W),
    .MIN_SHIFT(MIN_SHIFT), .WIN_BITS(WIN_BITS), .WIN_BASE(WIN_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIdx(cfgIdx),
    .cfgData(cfgData), .inValid(inValid), .inAddr(inAddr), .strb(strb),
    .selOffset(selOffset), .selHigh(selHigh), .sizeCode(sizeCode)
  );

  obx_dp #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MIN_SHIFT(MIN_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inAddr(inAddr),
    .selOffset(selOffset), .selHigh(selHigh), .sizeCode(sizeCode),
    .outValid(outValid), .outAddr(outAddr), .outHit(outHit), .outErr(outErr)
  );

endmodule

// File: tb/obx_top_tb.sv
`timescale 1ns/1ps
module obx_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [4:0]  cfgIdx = '0;
  logic [31:0] cfgData = '0;
  logic        inValid = 1'b0;
  logic [31:0] inAddr = '0;
  logic        outValid;
  logic [63:0] outAddr;
  logic        outHit;
  logic        outErr;

  always #2 clk = ~clk;

  obx_top u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIdx(cfgIdx),
    .cfgData(cfgData), .inValid(inValid), .inAddr(inAddr),
    .outValid(outValid), .outAddr(outAddr), .outHit(outHit), .outErr(outErr)
  );

  typedef struct {
    int          due;
    bit          v;
    bit          h;
    bit          e;
    logic [63:0] a;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  int          cyc = 0;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  // Shadow configuration
  bit          mEn = 1'b0;
  int          mSize = 0;
  logic [31:0] mOff[32];
  logic [31:0] mHigh[32];

  always @(posedge clk) cyc++;

  function automatic expItem_t model(input logic [31:0] a, input string tag);
    expItem_t it;
    int sh;
    int idx;
    logic [31:0] low;
    it.tag = tag; it.due = 0;
    it.v = 1; it.h = 0; it.e = 0; it.a = {32'h0, a};
    if (mEn && a[31:28] == 4'h6) begin
      sh  = 20 + mSize;
      idx = int'((a >> sh) & 32'h1F);
      low = (32'h1 << sh) - 32'h1;
      if (mOff[idx][0]) begin
        it.h = 1;
        it.a = {mHigh[idx], (mOff[idx] & ~low) | (a & low)};
      end else begin
        it.v = 0; it.e = 1; it.a = '0;
      end
    end
    return it;
  endfunction

  task automatic send(input logic [31:0] a, input string tag);
    expItem_t it;
    @(negedge clk);
    cfgWe = 0; inValid = 1; inAddr = a;
    it = model(a, tag);
    it.due = cyc + 1;
    expQ.push_back(it);
  endtask

  task automatic idle(input string tag);
    expItem_t it;
    @(negedge clk);
    cfgWe = 0; inValid = 0;
    it.due = cyc + 1; it.v = 0; it.h = 0; it.e = 0; it.a = '0; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input int idx, input logic [31:0] d);
    expItem_t it;
    @(negedge clk);
    inValid = 0; cfgWe = 1; cfgSel = sel; cfgIdx = 5'(idx); cfgData = d;
    case (sel)
      2'd0: mSize = int'(d[1:0]);
      2'd1: mEn = d[0];
      2'd2: mOff[idx] = d;
      default: mHigh[idx] = d;
    endcase
    it.due = cyc + 1; it.v = 0; it.h = 0; it.e = 0; it.a = '0; it.tag = "R9 cfg cycle";
    expQ.push_back(it);
  endtask

  // Monitor: compares results on the falling edge of their due cycle
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].due == cyc) begin
      expItem_t it;
      bit bad;
      it = expQ.pop_front();
      nChecks++;
      bad = (outValid !== it.v) || (outErr !== it.e) ||
            (it.v && ((outHit !== it.h) || (outAddr !== it.a)));
      if (bad) begin
        nFails++;
        $display("FAIL %s: got v%0b h%0b e%0b a=%h, expected v%0b h%0b e%0b a=%h",
                 it.tag, outValid, outHit, outErr, outAddr, it.v, it.h, it.e, it.a);
      end
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got no end, expected run to finish");
      finishRun();
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin mOff[i] = '0; mHigh[i] = '0; end
    repeat (3) @(negedge clk);
    nChecks++;
    if (outValid !== 1'b0 || outHit !== 1'b0 || outErr !== 1'b0) begin
      nFails++;
      $display("FAIL R1 reset: got v%0b h%0b e%0b, expected 0 0 0", outValid, outHit, outErr);
    end
    rstN = 1'b1;
    idle("R1 after reset");

    // R3: switch off, in-window address passes through
    send(32'h6001_5678, "R3 disabled pass");
    cfgWrite(2'd2, 0, 32'h9000_0001);
    cfgWrite(2'd3, 0, 32'h0);
    send(32'h6001_5678, "R3 disabled, region programmed");
    cfgWrite(2'd0, 0, 32'h0);
    cfgWrite(2'd1, 0, 32'h1);
    // R10 + R11: input the cycle right after enabling
    send(32'h6001_5678, "R11 worked example");
    // R4: outside the window
    send(32'h7000_0000, "R4 above window");
    send(32'h5FFF_FFFF, "R4 below window");
    // R7: upper word
    cfgWrite(2'd2, 3, 32'hA030_0001);
    cfgWrite(2'd3, 3, 32'h1234_5678);
    send(32'h6030_0ABC, "R7 upper word region 3");
    // R8: disabled region then back to back traffic (R2)
    send(32'h6050_0000, "R8 disabled region");
    send(32'h6030_0001, "R2 back to back after error");
    send(32'h6000_0000, "R2 back to back region 0");
    idle("R9 idle");
    idle("R9 idle 2");

    // Program all regions with distinct values
    for (int r = 0; r < 32; r++) begin
      cfgWrite(2'd2, r, {4'h8 + 4'(r % 8), 5'(r), 22'h0, (r % 5 != 0)});
      cfgWrite(2'd3, r, 32'h100 * r);
    end
    // R5/R6: each size code across many regions
    for (int s = 0; s < 4; s++) begin
      cfgWrite(2'd0, 0, 32'(s));
      for (int r = 0; r < 32; r++) begin
        logic [31:0] a;
        a = 32'h6000_0000 | (32'(r) << (20 + s)) | (32'h000A_5A5A & ((32'h1 << (20 + s)) - 1));
        a = a | (32'h0FFF_FFFF & ~((32'h1F << (20 + s)) | ((32'h1 << (20 + s)) - 1)) & 32'h0BAD_0000);
        send(a, $sformatf("R5 R6 size %0d region %0d", s, r));
      end
      idle("R9 gap");
    end

    // R10: a write to the region just used, then an immediate access
    cfgWrite(2'd0, 0, 32'h2);
    cfgWrite(2'd2, 7, 32'hC000_0000);
    send(32'h61C0_0010, "R10 region disabled by write");
    cfgWrite(2'd2, 7, 32'hC040_0001);
    send(32'h61C0_0010, "R10 region re-enabled");

    // R3 again: switch off
    cfgWrite(2'd1, 0, 32'h0);
    send(32'h61C0_0010, "R3 switched off again");
    send(32'h6050_0000, "R3 disabled region ignored when off");
    idle("R9 tail");
    idle("R9 tail 2");
    @(negedge clk);
    done = 1'b1;
    finishRun();
  end

endmodule